// File: doc/BRIEF.md
# Accumulator-Style 8-bit Execute Unit

This block is the execute stage of a small accumulator-based microcontroller core. Each clock it takes one 14-bit instruction word, one operand byte read from the file-register space and the present status flags. It computes a result byte and steers it either into its own working register W or back to the file location named by the instruction. It also produces new carry, digit-carry and zero flags. It raises a program-counter request for jumps, calls and load-and-return. When the following instruction must become a no-op, after a taken skip or any program-counter change, it says so.

All outputs are registered, so the effect of an instruction appears one clock after it is presented. The unit also acts on its own squash output. The instruction presented in the cycle in which squash is high is discarded: no write, no flag change, no request. The surrounding core supplies program memory, the return stack and the file storage.

Top module: `acc_exec_unit`

## Requirements
- R1: While `rst` is high, every output is driven to zero on each clock, W included.
- R2: With bits 13:12 = 00, opcode (bits 11:8) 0111 adds W and the file byte, and 0010 computes file minus W as an addition of the two's complement. C is the carry out of bit 7 (1 = no borrow), DC is the carry out of bit 3 and Z is set when the result is zero. Bit 7 = 0 sends the result to W, and bit 7 = 1 writes it to the file address in bits 6:0. The flag vectors are ordered {Z, DC, C} from bit 2 down to bit 0.
- R3: The byte opcodes AND 0101, inclusive OR 0100, exclusive OR 0110, complement 1001, decrement 0011, increment 1010, move 1000 and clear 0001 update only Z; C and DC pass through from `flags_in`. Opcode 0000 with bit 7 = 1 writes W to the file with flags unchanged.
- R4: Rotate left (1101) and rotate right (1100) shift through C and update C only.
- R5: Nibble swap (1110) exchanges the two halves of the file byte and leaves all flags as given.
- R6: Decrement-skip (1011) and increment-skip (1111) deliver their result as bit 7 selects, leave the flags unchanged, and assert `squash` when the result is zero.
- R7: With bits 13:12 = 01, bits 11:10 select bit-clear 00, bit-set 01, skip-if-clear 10 and skip-if-set 11 on the bit numbered by bits 9:7. Clear and set write the file byte. The tests assert `squash` when their condition holds. None of them changes W or the flags.
- R8: With bits 13:12 = 11, the 8-bit constant k in bits 7:0 is used as follows: bits 11:9 = 111 gives k+W and 110 gives k−W, both updating C, DC and Z. 1001 ANDs, 1000 ORs and 1010 XORs k with W, updating Z. 00xx loads k into W with flags unchanged. Every result goes to W.
- R9: With bits 13:12 = 10, bit 11 = 0 is a call (`pc_kind` 2) and bit 11 = 1 a jump (`pc_kind` 1) to the 11-bit target in bits 10:0. Both assert `pc_req` and `squash`.
- R10: Bits 13:8 = 1101xx load k into W, assert `pc_req` with `pc_kind` 3 and assert `squash`; the flags are unchanged.
- R11: The instruction presented while `squash` is high has no effect: W holds, `file_we` and `pc_req` stay low, `flags_out` equals `flags_in`, and `squash` falls.
- R12: Opcode 0000 with bit 7 = 0 and literal pattern 1011 are no-ops: W, the flags and the file are untouched and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 14 | Instruction word to execute |
| file_rdata | input | 8 | File byte at the instruction's address |
| flags_in | input | 3 | Present status flags {Z, DC, C} |
| w_value | output | 8 | Working register W |
| file_we | output | 1 | File write enable |
| file_waddr | output | 7 | File write address |
| file_wdata | output | 8 | File write data |
| flags_out | output | 3 | New status flags {Z, DC, C} |
| pc_req | output | 1 | Program-counter change requested |
| pc_kind | output | 2 | 1 jump, 2 call, 3 return |
| pc_target | output | 11 | Jump or call target |
| squash | output | 1 | Next presented instruction is discarded |

## Verification
Directed words first put operands on both sides of the carry and digit-carry boundaries (0x0F+0x01, 0xFF+0x01, equal and larger subtrahends), which separates a correct nibble carry from a full-byte carry and the borrow sense of C. Skip words are tried with operands that do and do not produce zero, or that present the tested bit in both states. Each is followed by a file-writing word, so a missing or spurious squash shows up as an extra or missing write. A long run of random words with random file data and random incoming flags then covers every class and both destinations. It also shows whether each opcode leaves the unaffected flags exactly as presented.

// File: rtl/acc_pkg.sv
package acc_pkg;
  parameter int unsigned DW   = 8;   // data byte width
  parameter int unsigned IW   = 14;  // instruction width
  parameter int unsigned FA_W = 7;   // file address width
  parameter int unsigned PA_W = 11;  // program address width
  parameter int unsigned NFL  = 3;   // flag count
  localparam int unsigned BN_W = $clog2(DW);

  localparam int FC  = 0;
  localparam int FDC = 1;
  localparam int FZ  = 2;

  localparam logic [1:0] PCK_NONE = 2'd0;
  localparam logic [1:0] PCK_JUMP = 2'd1;
  localparam logic [1:0] PCK_CALL = 2'd2;
  localparam logic [1:0] PCK_RET  = 2'd3;

  typedef enum logic [4:0] {
    OP_NOP, OP_ADD, OP_SUB, OP_AND, OP_IOR, OP_XOR, OP_COM, OP_DEC,
    OP_INC, OP_DECSK, OP_INCSK, OP_MOV, OP_RL, OP_RR, OP_SWAP, OP_CLR,
    OP_STW, OP_BCLR, OP_BSET, OP_BTSC, OP_BTSS, OP_LDK, OP_RET, OP_BRANCH
  } op_e;

  typedef struct packed {
    op_e             op;
    logic            lit;    // operand is the instruction constant
    logic            wr_w;   // result lands in W
    logic            wr_f;   // result lands in the file
    logic [1:0]      pck;    // program-counter request kind
    logic [BN_W-1:0] bitn;
  } dec_t;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [IW-1:7] ihi,
  output dec_t          dec
);
  logic [1:0] cls;
  logic [3:0] sub;
  logic       dsel;

  assign cls  = ihi[13:12];
  assign sub  = ihi[11:8];
  assign dsel = ihi[7];

  always_comb begin
    dec      = '0;
    dec.op   = OP_NOP;
    dec.bitn = ihi[9:7];
    dec.lit  = (cls == 2'b11);
    unique case (cls)
      2'b00: begin
        dec.wr_w = ~dsel;
        dec.wr_f = dsel;
        unique case (sub)
          4'h7: dec.op = OP_ADD;
          4'h2: dec.op = OP_SUB;
          4'h5: dec.op = OP_AND;
          4'h4: dec.op = OP_IOR;
          4'h6: dec.op = OP_XOR;
          4'h9: dec.op = OP_COM;
          4'h3: dec.op = OP_DEC;
          4'hA: dec.op = OP_INC;
          4'hB: dec.op = OP_DECSK;
          4'hF: dec.op = OP_INCSK;
          4'h8: dec.op = OP_MOV;
          4'hD: dec.op = OP_RL;
          4'hC: dec.op = OP_RR;
          4'hE: dec.op = OP_SWAP;
          4'h1: dec.op = OP_CLR;
          default: begin
            dec.op   = dsel ? OP_STW : OP_NOP;
            dec.wr_w = 1'b0;
          end
        endcase
      end
      2'b01: begin
        unique case (sub[3:2])
          2'b00:   dec.op = OP_BCLR;
          2'b01:   dec.op = OP_BSET;
          2'b10:   dec.op = OP_BTSC;
          default: dec.op = OP_BTSS;
        endcase
        dec.wr_f = ~sub[3];
      end
      2'b10: begin
        dec.op  = OP_BRANCH;
        dec.pck = sub[3] ? PCK_JUMP : PCK_CALL;
      end
      default: begin
        dec.wr_w = 1'b1;
        casez (sub)
          4'b111?: dec.op = OP_ADD;
          4'b110?: dec.op = OP_SUB;
          4'b1001: dec.op = OP_AND;
          4'b1000: dec.op = OP_IOR;
          4'b1010: dec.op = OP_XOR;
          4'b00??: dec.op = OP_LDK;
          4'b01??: begin
            dec.op  = OP_RET;
            dec.pck = PCK_RET;
          end
          default: begin
            dec.op   = OP_NOP;
            dec.wr_w = 1'b0;
          end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
(
  input  op_e              op,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    w,
  input  logic [BN_W-1:0]  bitn,
  input  logic [NFL-1:0]   flags_i,
  output logic [DW-1:0]    res,
  output logic [NFL-1:0]   flags_o,
  output logic             skip
);
  localparam int HN = DW / 2;

  logic          is_sub;
  logic [DW-1:0] bx;
  logic [DW:0]   sum;
  logic [HN:0]   nib;
  logic [DW-1:0] mask;
  logic          upd_z;

  assign is_sub = (op == OP_SUB);
  assign bx     = is_sub ? ~w : w;
  assign sum    = {1'b0, a} + {1'b0, bx} + {{DW{1'b0}}, is_sub};
  assign nib    = {1'b0, a[HN-1:0]} + {1'b0, bx[HN-1:0]} + {{HN{1'b0}}, is_sub};
  assign mask   = {{(DW-1){1'b0}}, 1'b1} << bitn;

  always_comb begin
    res     = '0;
    flags_o = flags_i;
    skip    = 1'b0;
    upd_z   = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        res          = sum[DW-1:0];
        flags_o[FC]  = sum[DW];
        flags_o[FDC] = nib[HN];
        upd_z        = 1'b1;
      end
      OP_AND: begin res = a & w; upd_z = 1'b1; end
      OP_IOR: begin res = a | w; upd_z = 1'b1; end
      OP_XOR: begin res = a ^ w; upd_z = 1'b1; end
      OP_COM: begin res = ~a;    upd_z = 1'b1; end
      OP_DEC: begin res = a - 1'b1; upd_z = 1'b1; end
      OP_INC: begin res = a + 1'b1; upd_z = 1'b1; end
      OP_MOV: begin res = a;     upd_z = 1'b1; end
      OP_CLR: begin res = '0;    upd_z = 1'b1; end
      OP_DECSK: begin
        res  = a - 1'b1;
        skip = (res == '0);
      end
      OP_INCSK: begin
        res  = a + 1'b1;
        skip = (res == '0);
      end
      OP_RL: begin
        res         = {a[DW-2:0], flags_i[FC]};
        flags_o[FC] = a[DW-1];
      end
      OP_RR: begin
        res         = {flags_i[FC], a[DW-1:1]};
        flags_o[FC] = a[0];
      end
      OP_SWAP: res = {a[HN-1:0], a[DW-1:HN]};
      OP_STW:  res = w;
      OP_BCLR: res = a & ~mask;
      OP_BSET: res = a | mask;
      OP_BTSC: skip = ((a & mask) == '0);
      OP_BTSS: skip = ((a & mask) != '0);
      OP_LDK, OP_RET: res = a;
      default: res = '0;
    endcase
    if (upd_z) flags_o[FZ] = (res == '0);
  end
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [13:0]     instr,
  input  logic [7:0]      file_rdata,
  input  logic [2:0]      flags_in,
  output logic [7:0]      w_value,
  output logic            file_we,
  output logic [6:0]      file_waddr,
  output logic [7:0]      file_wdata,
  output logic [2:0]      flags_out,
  output logic            pc_req,
  output logic [1:0]      pc_kind,
  output logic [10:0]     pc_target,
  output logic            squash
);
  dec_t            dec;
  logic [DW-1:0]   opnd;
  logic [DW-1:0]   alu_res;
  logic [NFL-1:0]  alu_flags;
  logic            alu_skip;
  logic            live;

  logic [DW-1:0]   w_q;
  logic            we_q;
  logic [FA_W-1:0] waddr_q;
  logic [DW-1:0]   wdata_q;
  logic [NFL-1:0]  flags_q;
  logic            pcr_q;
  logic [1:0]      pck_q;
  logic [PA_W-1:0] tgt_q;
  logic            sq_q;

  acc_decode u_dec (
    .ihi (instr[IW-1:7]),
    .dec (dec)
  );

  assign opnd = dec.lit ? instr[DW-1:0] : file_rdata;

  acc_alu u_alu (
    .op      (dec.op),
    .a       (opnd),
    .w       (w_q),
    .bitn    (dec.bitn),
    .flags_i (flags_in),
    .res     (alu_res),
    .flags_o (alu_flags),
    .skip    (alu_skip)
  );

  assign live = ~sq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q     <= '0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
      flags_q <= '0;
      pcr_q   <= 1'b0;
      pck_q   <= PCK_NONE;
      tgt_q   <= '0;
      sq_q    <= 1'b0;
    end else begin
      we_q    <= live & dec.wr_f;
      waddr_q <= instr[FA_W-1:0];
      wdata_q <= alu_res;
      flags_q <= live ? alu_flags : flags_in;
      pcr_q   <= live & (dec.pck != PCK_NONE);
      pck_q   <= dec.pck;
      tgt_q   <= instr[PA_W-1:0];
      sq_q    <= live & ((dec.pck != PCK_NONE) | alu_skip);
      if (live & dec.wr_w) w_q <= alu_res;
    end
  end

  assign w_value    = w_q;
  assign file_we    = we_q;
  assign file_waddr = waddr_q;
  assign file_wdata = wdata_q;
  assign flags_out  = flags_q;
  assign pc_req     = pcr_q;
  assign pc_kind    = pck_q;
  assign pc_target  = tgt_q;
  assign squash     = sq_q;

  // R11: squash never lasts two cycles
  p_squash_single_r11: assert property (@(posedge clk) disable iff (rst)
    sq_q |=> !sq_q);

  // R11: a discarded instruction leaves W and requests untouched
  p_killed_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    sq_q |=> (!we_q && !pcr_q && $stable(w_q)));

  // R9: every program-counter request also squashes
  p_pcreq_squash_r9: assert property (@(posedge clk) disable iff (rst)
    pcr_q |-> sq_q);

  // R5: swap passes the incoming flags through
  p_swap_flags_r5: assert property (@(posedge clk) disable iff (rst)
    (live && dec.op == OP_SWAP) |=> (flags_q == $past(flags_in)));

  // R7: bit operations never alter W
  p_bitop_keeps_w_r7: assert property (@(posedge clk) disable iff (rst)
    (instr[13:12] == 2'b01) |=> $stable(w_q));
endmodule

// File: tb/acc_exec_unit_tb.sv
module acc_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] instr = '0;
  logic [7:0]  file_rdata = '0;
  logic [2:0]  flags_in = '0;
  logic [7:0]  w_value;
  logic        file_we;
  logic [6:0]  file_waddr;
  logic [7:0]  file_wdata;
  logic [2:0]  flags_out;
  logic        pc_req;
  logic [1:0]  pc_kind;
  logic [10:0] pc_target;
  logic        squash;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int m_w = 0;
  bit m_kill = 1'b0;

  always #5 clk = ~clk;

  acc_exec_unit dut_i (
    .clk(clk), .rst(rst), .instr(instr), .file_rdata(file_rdata),
    .flags_in(flags_in), .w_value(w_value), .file_we(file_we),
    .file_waddr(file_waddr), .file_wdata(file_wdata), .flags_out(flags_out),
    .pc_req(pc_req), .pc_kind(pc_kind), .pc_target(pc_target), .squash(squash)
  );

  function automatic string req_of(logic [13:0] ins);
    int o;
    o = ins[11:8];
    case (ins[13:12])
      2'd0: begin
        if (o == 7 || o == 2) return "R2";
        if (o == 13 || o == 12) return "R4";
        if (o == 14) return "R5";
        if (o == 11 || o == 15) return "R6";
        if (o == 0 && !ins[7]) return "R12";
        return "R3";
      end
      2'd1: return "R7";
      2'd2: return "R9";
      default: begin
        if (o >= 4 && o <= 7) return "R10";
        if (o == 11) return "R12";
        return "R8";
      end
    endcase
  endfunction

  function automatic logic [41:0] pack_out(int w, bit we, int ad, int wd,
      logic [2:0] fl, bit pc, int kd, int tg, bit sq);
    logic [41:0] v;
    v = {w[7:0], we, we ? ad[6:0] : 7'd0, we ? wd[7:0] : 8'd0, fl,
         pc, pc ? kd[1:0] : 2'd0, pc ? tg[10:0] : 11'd0, sq};
    return v;
  endfunction

  task automatic check(string rq, logic [41:0] act, logic [41:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s instr=%h actual=%h expected=%h", rq, instr, act, exp);
    end
  endtask

  task automatic step(logic [13:0] ins, logic [7:0] fd, logic [2:0] fl);
    int f, a, res, o, bn, kd;
    bit c, dc, z, uz, wr_w, wr_f, skip, pc;
    string rq;
    logic [41:0] exp, act;
    @(negedge clk);
    instr = ins; file_rdata = fd; flags_in = fl;
    f = fd; o = ins[11:8]; bn = ins[9:7];
    c = fl[0]; dc = fl[1]; z = fl[2];
    uz = 0; wr_w = 0; wr_f = 0; skip = 0; pc = 0; res = 0; kd = 0;
    rq = m_kill ? "R11" : req_of(ins);
    if (!m_kill) begin
      a = (ins[13:12] == 2'd3) ? int'(ins[7:0]) : f;
      case (ins[13:12])
        2'd0: begin
          wr_w = !ins[7]; wr_f = ins[7];
          case (o)
            7: begin res = a + m_w; c = res > 255; dc = (a % 16 + m_w % 16) > 15; uz = 1; end
            2: begin res = (a - m_w + 256) % 256; c = a >= m_w; dc = (a % 16) >= (m_w % 16); uz = 1; end
            5: begin res = a & m_w; uz = 1; end
            4: begin res = a | m_w; uz = 1; end
            6: begin res = a ^ m_w; uz = 1; end
            9: begin res = 255 - a; uz = 1; end
            3: begin res = (a + 255) % 256; uz = 1; end
            10: begin res = (a + 1) % 256; uz = 1; end
            11: begin res = (a + 255) % 256; skip = (res == 0); end
            15: begin res = (a + 1) % 256; skip = (res == 0); end
            8: begin res = a; uz = 1; end
            13: begin res = (a * 2 + c) % 256; c = a >= 128; end
            12: begin res = a / 2 + (c ? 128 : 0); c = a % 2; end
            14: res = (a % 16) * 16 + a / 16;
            1: begin res = 0; uz = 1; end
            default: begin wr_w = 0; res = m_w; end
          endcase
        end
        2'd1: begin
          case (ins[11:10])
            2'd0: begin res = f & (255 - (1 << bn)); wr_f = 1; end
            2'd1: begin res = f | (1 << bn); wr_f = 1; end
            2'd2: skip = ((f >> bn) % 2) == 0;
            default: skip = ((f >> bn) % 2) == 1;
          endcase
        end
        2'd2: begin pc = 1; kd = ins[11] ? 1 : 2; end
        default: begin
          wr_w = 1;
          if (o >= 14) begin res = a + m_w; c = res > 255; dc = (a % 16 + m_w % 16) > 15; uz = 1; end
          else if (o >= 12) begin res = (a - m_w + 256) % 256; c = a >= m_w; dc = (a % 16) >= (m_w % 16); uz = 1; end
          else if (o == 9) begin res = a & m_w; uz = 1; end
          else if (o == 8) begin res = a | m_w; uz = 1; end
          else if (o == 10) begin res = a ^ m_w; uz = 1; end
          else if (o == 11) wr_w = 0;
          else if (o < 4) res = a;
          else begin res = a; pc = 1; kd = 3; end
        end
      endcase
      res = res % 256;
      if (uz) z = (res == 0);
      if (wr_w) m_w = res;
      m_kill = pc || skip;
    end else begin
      m_kill = 0;
    end
    exp = pack_out(m_w, wr_f, int'(ins[6:0]), res, {z, dc, c}, pc, kd,
                   int'(ins[10:0]), pc || skip);
    @(posedge clk); #1;
    act = pack_out(int'(w_value), file_we, int'(file_waddr), int'(file_wdata),
                   flags_out, pc_req, int'(pc_kind), int'(pc_target), squash);
    check(rq, act, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    instr = 14'h0780; file_rdata = 8'h5A; flags_in = 3'b111;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", pack_out(int'(w_value), file_we, int'(file_waddr), int'(file_wdata),
                         flags_out, pc_req, int'(pc_kind), int'(pc_target), squash),
          42'd0);
    @(negedge clk); rst = 1'b0;

    // R8 literal loads and arithmetic
    step(14'h300F, 8'h00, 3'b000);
    step(14'h3E01, 8'h00, 3'b000);          // 0x0F+0x01: DC
    step(14'h3CFF, 8'h00, 3'b000);          // 0xFF-0x10
    step(14'h39F0, 8'h00, 3'b111);
    step(14'h380F, 8'h00, 3'b000);
    step(14'h3AFF, 8'h00, 3'b000);
    // R2 byte add / subtract with both destinations
    step(14'h30FF, 8'h00, 3'b000);
    step(14'h0710, 8'h01, 3'b000);          // 0xFF+0x01 -> 0 to W
    step(14'h30FF, 8'h00, 3'b000);
    step(14'h0791, 8'h01, 3'b000);          // to file
    step(14'h0222, 8'hFF, 3'b000);          // equal: no borrow
    step(14'h3020, 8'h00, 3'b000);
    step(14'h02A3, 8'h10, 3'b111);          // borrow
    // R4 R5 R3
    step(14'h0D85, 8'h81, 3'b001);
    step(14'h0C05, 8'h01, 3'b000);
    step(14'h0E86, 8'hA5, 3'b110);
    step(14'h0187, 8'h33, 3'b000);
    step(14'h0088, 8'h00, 3'b000);
    // R6 skip taken then a writer that must be discarded (R11)
    step(14'h0B89, 8'h01, 3'b000);
    step(14'h0780, 8'h11, 3'b000);
    step(14'h0F0A, 8'h05, 3'b000);
    step(14'h0F8A, 8'hFF, 3'b000);
    step(14'h01AB, 8'h77, 3'b000);
    // R7 bit ops
    step(14'h138C, 8'h00, 3'b010);
    step(14'h160D, 8'hFF, 3'b000);
    step(14'h1A0E, 8'h00, 3'b000);
    step(14'h3EFF, 8'h00, 3'b000);
    step(14'h1E0E, 8'h00, 3'b000);
    step(14'h1E8E, 8'h02, 3'b000);
    step(14'h0780, 8'h11, 3'b000);
    // R9 R10 R12
    step(14'h2ABC, 8'h00, 3'b000);
    step(14'h3E01, 8'h00, 3'b000);
    step(14'h2123, 8'h00, 3'b000);
    step(14'h3455, 8'h00, 3'b101);
    step(14'h3B12, 8'h00, 3'b000);
    step(14'h0064, 8'h00, 3'b011);
    step(14'h0000, 8'h00, 3'b100);
    // random coverage of all classes
    for (int i = 0; i < 4000; i++)
      step(14'($urandom), 8'($urandom), 3'($urandom));
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule